// File: doc/BRIEF.md
# Audio Channel Count Converter

A streaming stage that sits between a multichannel sample stream (the audio side) and a client port that may expect a different number of channels. Samples enter one per cycle with a valid/ready handshake and a marker on the first channel of each frame. Depending on the two configured channel counts, the block narrows a stereo stream to mono, widens a mono stream to stereo, or forwards samples untouched.

Narrowing keeps channel 0, keeps channel 1, or emits the signed mean of the pair. Widening appends a second channel that is either silent or a duplicate of the mono sample. Samples are right-aligned in a 32-bit word, and a width select (8, 16 or 32 bits) tells the mean which bit is the sign. Alongside the stream, the block turns a requested FIFO threshold (in frames) into a clamped value that the FIFO will accept for the configured audio channel count.

Back-pressure rules: an output sample, once valid, stays valid and unchanged until `out_ready` is high. Input is taken only when `in_valid` and `in_ready` are both high. In narrowing mode a channel-0 sample can be taken even while the output is stalled, because it only fills an internal holding register. While the copy or zero half of a widened pair is waiting to leave, `in_ready` is low.

Top module: `audio_chan_conv`

## Requirements
- R1: When neither conversion applies, every accepted sample appears on the output with identical data and first marker. `out_valid` rises on the clock edge right after the sample is accepted.
- R2: Narrowing with `cfg_s2m_mode` = 0 outputs the channel-0 sample (the sample with `in_first` = 1) of each pair.
- R3: Narrowing with `cfg_s2m_mode` = 1 outputs the channel-1 sample (`in_first` = 0) of each pair.
- R4: Narrowing with `cfg_s2m_mode` = 2 works as follows. Each sample of the pair is sign-extended from the width chosen by `cfg_width` (0 = 8, 1 = 16, 2 or 3 = 32 bits). The two are added in 33 bits and the sum is shifted right arithmetically by one. The output is the 32-bit result, so it cannot overflow.
- R5: In narrowing, each input pair gives exactly one output sample, and that sample has `out_first` = 1. The output is loaded on the edge that accepts the channel-1 sample.
- R6: In widening, each mono sample gives two output samples in order. The first carries the input data and marker. The second has `out_first` = 0 and carries zero when `cfg_m2s_mode` = 0, or the input data when `cfg_m2s_mode` = 1.
- R7: While `out_valid` is high and `out_ready` is low, the output holds its data and marker. A widened pair is never interleaved with a new input: `in_ready` is low on the cycle after a mono sample is accepted.
- R8: `thresh_out` is updated every cycle to the smaller of `cfg_thresh_req` and FIFO_DEPTH/n − 1, where n is `cfg_audio_ch`. A value of 0 is treated as 1 and values above MAX_CH are treated as MAX_CH. With the default depth of 64: n = 3 gives 20, n = 16 gives 3.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and `thresh_out` is 0.
- R10: Narrowing is selected only when the audio count is 2 and the client count is 1. Widening is selected only when the audio count is 1 and the client count is 2. Every other pair of counts (for example 4 and 2) passes samples through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_audio_ch | input | 5 | Audio-side channel count (1..16) |
| cfg_client_ch | input | 5 | Client-side channel count (1..16) |
| cfg_s2m_mode | input | 2 | Narrowing choice: 0 ch0, 1 ch1, 2 mean |
| cfg_m2s_mode | input | 1 | Widening fill: 0 zero, 1 copy |
| cfg_width | input | 2 | Sample width: 0 = 8, 1 = 16, else 32 bits |
| cfg_thresh_req | input | 6 | Requested FIFO threshold in frames |
| thresh_out | output | 6 | Clamped FIFO threshold in frames |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 32 | Input sample, right-aligned |
| in_first | input | 1 | Input sample is channel 0 of its frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts output sample |
| out_data | output | 32 | Output sample |
| out_first | output | 1 | Output sample is channel 0 of its frame |

## Verification
Properties are checked on every cycle for the following:
- output stability under stall;
- the one-edge forwarding of pass-through data;
- the marker on narrowed and widened samples;
- the closed `in_ready` window after a widening accept;
- the clamp never exceeding the request.

The value of each narrowed sample (the channel choice and the signed mean at every width, including the extreme-sign corners) can only be shown by the bench's scenarios. The same holds for the fill of the second widened sample, the exact clamp table values, and the mode decode for unequal counts other than 2:1 and 1:2. For those, the bench compares complete output sequences against its own model under random stalls.

// File: rtl/chconv_pkg.sv
package chconv_pkg;
  parameter int SMP_W = 32;

  typedef enum logic [1:0] {
    SEL_CH0 = 2'd0,
    SEL_CH1 = 2'd1,
    SEL_AVG = 2'd2
  } s2m_sel_e;

  // Sign-extend a right-aligned sample of the selected width to SMP_W bits.
  function automatic logic [SMP_W-1:0] sign_fill(input logic [SMP_W-1:0] v,
                                                 input logic [1:0] wsel);
    case (wsel)
      2'd0:    sign_fill = {{(SMP_W-8){v[7]}}, v[7:0]};
      2'd1:    sign_fill = {{(SMP_W-16){v[15]}}, v[15:0]};
      default: sign_fill = v;
    endcase
  endfunction
endpackage

// File: rtl/chconv_avg.sv
module chconv_avg
  import chconv_pkg::*;
(
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  input  logic [1:0]       wsel,
  output logic [SMP_W-1:0] mean
);
  logic [SMP_W-1:0] ext_a, ext_b;
  logic [SMP_W:0]   sum;

  assign ext_a = sign_fill(smp_a, wsel);
  assign ext_b = sign_fill(smp_b, wsel);
  // One guard bit keeps the sum exact; dropping bit 0 is the arithmetic halving.
  assign sum   = {ext_a[SMP_W-1], ext_a} + {ext_b[SMP_W-1], ext_b};
  assign mean  = sum[SMP_W:1];
endmodule

// File: rtl/chconv_thresh.sv
module chconv_thresh #(
  parameter int MAX_CH     = 16,
  parameter int FIFO_DEPTH = 64,
  localparam int CH_W      = $clog2(MAX_CH + 1),
  localparam int TH_W      = $clog2(FIFO_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] audio_ch,
  input  logic [TH_W-1:0] req,
  output logic [TH_W-1:0] clamped
);
  logic [TH_W-1:0] limit_tab [MAX_CH+1];
  logic [CH_W-1:0] idx;
  logic [TH_W-1:0] lim;

  assign limit_tab[0] = TH_W'(FIFO_DEPTH - 1);
  for (genvar c = 1; c <= MAX_CH; c++) begin : g_lim
    assign limit_tab[c] = TH_W'(FIFO_DEPTH / c - 1);
  end

  assign idx = (audio_ch > CH_W'(MAX_CH)) ? CH_W'(MAX_CH) : audio_ch;
  assign lim = limit_tab[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) clamped <= '0;
    else        clamped <= (req < lim) ? req : lim;
  end
endmodule

// File: rtl/audio_chan_conv.sv
module audio_chan_conv
  import chconv_pkg::*;
#(
  parameter int MAX_CH     = 16,
  parameter int FIFO_DEPTH = 64,
  localparam int CH_W      = $clog2(MAX_CH + 1),
  localparam int TH_W      = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  cfg_audio_ch,
  input  logic [CH_W-1:0]  cfg_client_ch,
  input  logic [1:0]       cfg_s2m_mode,
  input  logic             cfg_m2s_mode,
  input  logic [1:0]       cfg_width,
  input  logic [TH_W-1:0]  cfg_thresh_req,
  output logic [TH_W-1:0]  thresh_out,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_data,
  input  logic             in_first,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_data,
  output logic             out_first
);
  logic             narrow_m, widen_m;
  logic             can_load, in_fire;
  logic             ov_q, of_q, pend_q;
  logic [SMP_W-1:0] od_q, pend_d_q, hold_q;
  logic [SMP_W-1:0] mean, picked;

  assign narrow_m = (cfg_audio_ch == CH_W'(2)) && (cfg_client_ch == CH_W'(1));
  assign widen_m  = (cfg_audio_ch == CH_W'(1)) && (cfg_client_ch == CH_W'(2));

  assign can_load = !ov_q || out_ready;
  assign in_ready = !pend_q && (can_load || (narrow_m && in_first));
  assign in_fire  = in_valid && in_ready;

  chconv_avg u_avg (
    .smp_a (hold_q),
    .smp_b (in_data),
    .wsel  (cfg_width),
    .mean  (mean)
  );

  always_comb begin
    case (s2m_sel_e'(cfg_s2m_mode))
      SEL_CH1: picked = in_data;
      SEL_AVG: picked = mean;
      default: picked = hold_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q     <= 1'b0;
      of_q     <= 1'b0;
      od_q     <= '0;
      pend_q   <= 1'b0;
      pend_d_q <= '0;
      hold_q   <= '0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (pend_q && can_load) begin
        ov_q   <= 1'b1;
        od_q   <= pend_d_q;
        of_q   <= 1'b0;
        pend_q <= 1'b0;
      end else if (in_fire) begin
        if (narrow_m) begin
          if (in_first) begin
            hold_q <= in_data;
          end else begin
            ov_q <= 1'b1;
            od_q <= picked;
            of_q <= 1'b1;
          end
        end else if (widen_m) begin
          ov_q     <= 1'b1;
          od_q     <= in_data;
          of_q     <= in_first;
          pend_q   <= 1'b1;
          pend_d_q <= cfg_m2s_mode ? in_data : '0;
        end else begin
          ov_q <= 1'b1;
          od_q <= in_data;
          of_q <= in_first;
        end
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_first = of_q;

  chconv_thresh #(.MAX_CH(MAX_CH), .FIFO_DEPTH(FIFO_DEPTH)) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .audio_ch (cfg_audio_ch),
    .req      (cfg_thresh_req),
    .clamped  (thresh_out)
  );
endmodule

// File: rtl/audio_chan_conv_chk.sv
module audio_chan_conv_chk #(
  parameter int CH_W = 5,
  parameter int TH_W = 6,
  parameter int SW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CH_W-1:0] cfg_audio_ch,
  input logic [CH_W-1:0] cfg_client_ch,
  input logic [TH_W-1:0] cfg_thresh_req,
  input logic [TH_W-1:0] thresh_out,
  input logic            in_valid,
  input logic            in_ready,
  input logic [SW-1:0]   in_data,
  input logic            in_first,
  input logic            out_valid,
  input logic            out_ready,
  input logic [SW-1:0]   out_data,
  input logic            out_first
);
  logic nar, wid, acc;
  assign nar = cfg_audio_ch == CH_W'(2) && cfg_client_ch == CH_W'(1);
  assign wid = cfg_audio_ch == CH_W'(1) && cfg_client_ch == CH_W'(2);
  assign acc = in_valid && in_ready;

  assert_pass_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nar && !wid && acc) |=> (out_valid && out_data == $past(in_data) && out_first == $past(in_first)));

  assert_narrow_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nar && acc && !in_first) |=> (out_valid && out_first));

  assert_widen_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wid && acc) |=> (out_valid && out_first == $past(in_first) && out_data == $past(in_data)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));

  assert_pair_unsplit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wid && acc) |=> !in_ready);

  assert_clamp_le_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (thresh_out <= $past(cfg_thresh_req)));
endmodule

bind audio_chan_conv audio_chan_conv_chk #(.CH_W(CH_W), .TH_W(TH_W), .SW(chconv_pkg::SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_audio_ch(cfg_audio_ch), .cfg_client_ch(cfg_client_ch),
  .cfg_thresh_req(cfg_thresh_req), .thresh_out(thresh_out),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_first(out_first)
);

// File: tb/audio_chan_conv_tb_top.sv
`timescale 1ns/1ps
module audio_chan_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_audio_ch = 5'd2, cfg_client_ch = 5'd2;
  logic [1:0]  cfg_s2m_mode = 2'd0, cfg_width = 2'd2;
  logic        cfg_m2s_mode = 1'b0;
  logic [5:0]  cfg_thresh_req = 6'd0;
  logic [5:0]  thresh_out;
  logic        in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_first;
  logic [31:0] in_data = '0, out_data;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] stim_d [64];
  logic        stim_f [64];
  int          stim_n;
  logic [31:0] exp_d [$];
  logic        exp_f [$];

  always #2.5 clk = ~clk;

  audio_chan_conv dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] v, input logic [1:0] w);
    case (w)
      2'd0:    return {{24{v[7]}}, v[7:0]};
      2'd1:    return {{16{v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] mean_of(input logic [31:0] a, input logic [31:0] b, input logic [1:0] w);
    logic [31:0] ea, eb;
    logic [32:0] s;
    ea = sx(a, w);
    eb = sx(b, w);
    s  = {ea[31], ea} + {eb[31], eb};
    return s[32:1];
  endfunction

  task automatic add_stim(input logic [31:0] d, input logic f);
    stim_d[stim_n] = d;
    stim_f[stim_n] = f;
    stim_n++;
  endtask

  task automatic push_exp(input logic [31:0] d, input logic f);
    exp_d.push_back(d);
    exp_f.push_back(f);
  endtask

  // Pair of narrowing inputs with its expected output (R2, R3, R4)
  task automatic add_pair(input logic [31:0] a, input logic [31:0] b);
    add_stim(a, 1'b1);
    add_stim(b, 1'b0);
    case (cfg_s2m_mode)
      2'd1:    push_exp(b, 1'b1);
      2'd2:    push_exp(mean_of(a, b, cfg_width), 1'b1);
      default: push_exp(a, 1'b1);
    endcase
  endtask

  task automatic add_mono(input logic [31:0] x);
    add_stim(x, 1'b1);
    push_exp(x, 1'b1);
    push_exp(cfg_m2s_mode ? x : 32'd0, 1'b0);
  endtask

  task automatic run_stream(input string tag);
    int idx = 0;
    int guard = 0;
    bit prev_stall = 0;
    logic [31:0] prev_d = '0;
    logic prev_f = 1'b0;
    while ((idx < stim_n || exp_d.size() != 0) && guard < 3000) begin
      @(negedge clk);
      guard++;
      out_ready = ($urandom % 4) != 0;
      if (idx < stim_n && ($urandom % 4) != 0) begin
        in_valid = 1'b1; in_data = stim_d[idx]; in_first = stim_f[idx];
      end else begin
        in_valid = 1'b0; in_data = $urandom; in_first = $urandom;
      end
      #1;
      if (prev_stall)  // R7: stalled output must hold
        chk(out_valid && out_data == prev_d && out_first == prev_f, {"R7 ", tag}, out_data, prev_d);
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) chk(1'b0, {"R5 extra output ", tag}, out_data, 32'hx);
        else begin
          chk(out_data == exp_d[0] && out_first == exp_f[0], tag,
              {out_data[30:0], out_first}, {exp_d[0][30:0], exp_f[0]});
          void'(exp_d.pop_front());
          void'(exp_f.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      prev_f = out_first;
      if (in_valid && in_ready) idx++;
    end
    if (guard >= 3000) chk(1'b0, {"stream timeout ", tag}, 32'(exp_d.size()), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    stim_n = 0;
  endtask

  task automatic thr_case(input logic [4:0] ch, input logic [5:0] req, input logic [5:0] expv);
    @(negedge clk);
    cfg_audio_ch = ch;
    cfg_thresh_req = req;
    @(negedge clk);
    chk(thresh_out == expv, "R8 threshold clamp", 32'(thresh_out), 32'(expv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    stim_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready && thresh_out == 6'd0, "R9 reset state",
        {out_valid, in_ready, 24'd0, thresh_out}, 32'h4000_0000);
    rst_n = 1'b1;

    // R8 clamp table (depth 64)
    thr_case(5'd3, 6'd63, 6'd20);
    thr_case(5'd1, 6'd10, 6'd10);
    thr_case(5'd16, 6'd63, 6'd3);
    thr_case(5'd0, 6'd50, 6'd50);
    thr_case(5'd31, 6'd63, 6'd3);

    // R1 pass-through, equal counts
    cfg_audio_ch = 5'd2; cfg_client_ch = 5'd2;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] d = $urandom;
      add_stim(d, i[0] == 1'b0);
      push_exp(d, i[0] == 1'b0);
    end
    run_stream("R1 pass 2:2");

    // R10 unequal counts other than 2:1 / 1:2 pass through
    cfg_audio_ch = 5'd4; cfg_client_ch = 5'd2;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d = $urandom;
      add_stim(d, i % 4 == 0);
      push_exp(d, i % 4 == 0);
    end
    run_stream("R10 pass 4:2");

    // Narrowing modes R2, R3, R4, R5
    cfg_audio_ch = 5'd2; cfg_client_ch = 5'd1; cfg_width = 2'd2;
    cfg_s2m_mode = 2'd0;
    for (int i = 0; i < 10; i++) add_pair($urandom, $urandom);
    run_stream("R2 narrow ch0");
    cfg_s2m_mode = 2'd1;
    for (int i = 0; i < 10; i++) add_pair($urandom, $urandom);
    run_stream("R3 narrow ch1");
    cfg_s2m_mode = 2'd2;
    for (int i = 0; i < 10; i++) add_pair($urandom, $urandom);
    add_pair(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    add_pair(32'h8000_0000, 32'h8000_0000);
    add_pair(32'h8000_0000, 32'hFFFF_FFFF);
    run_stream("R4 mean 32b");
    cfg_width = 2'd1;
    for (int i = 0; i < 8; i++) add_pair($urandom, $urandom);
    add_pair(32'h0000_7FFF, 32'h0000_7FFF);
    add_pair(32'h1234_8000, 32'hABCD_8001);
    run_stream("R4 mean 16b");
    cfg_width = 2'd0;
    for (int i = 0; i < 8; i++) add_pair($urandom, $urandom);
    add_pair(32'h0000_007F, 32'h0000_0001);
    add_pair(32'h0000_0080, 32'h0000_00FF);
    run_stream("R4 mean 8b");

    // Widening R6 with back-pressure R7
    cfg_audio_ch = 5'd1; cfg_client_ch = 5'd2; cfg_width = 2'd2;
    cfg_m2s_mode = 1'b0;
    for (int i = 0; i < 12; i++) add_mono($urandom);
    run_stream("R6 widen zero");
    cfg_m2s_mode = 1'b1;
    for (int i = 0; i < 12; i++) add_mono($urandom);
    run_stream("R6 widen copy");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule